// File: doc/BRIEF.md
# Bus Cycle Terminator with Error, Retry and Halt Handling

This block is a bus master for an asynchronous handshake bus. A core hands it one request at a time: a read, a write or a read-modify-write, along with an address, a function code and write data. The block runs the cycle with an address strobe and a data strobe. It then waits for the far end to answer with an acknowledge, an error, or an error together with halt. The acknowledge, error and halt inputs each pass through a two-flop synchronizer before the sequencer acts on them.

An acknowledge completes the cycle normally. An error with halt negated aborts the cycle. The address and data enables stay off while the error is held, and a bus-error exception request that carries vector 2 (table byte offset 0x08) follows once the error drops. An error with halt asserted parks the bus in high impedance. When halt is released, the block replays the same cycle. A read-modify-write is never replayed. An error that arrives one clock after the acknowledge still counts.

A halt with no error lets the cycle in progress finish and then keeps new cycles from starting. Each request ends with a one-cycle completion pulse that carries a status code and the captured read data.

Top module: `bus_err_retry_ctrl`

## Requirements
- R1: A cycle answered by acknowledge alone ends with exactly one `done_valid` pulse, status 0 (ok) and, for reads, `done_rdata` equal to the bus data present during the acknowledge. The request kind is encoded as 0 read, 1 write, 2 read-modify-write.
- R2: An error while acknowledge and halt are negated ends the cycle with status 1 (bus error), one `exc_req` pulse, and `exc_vector` equal to 2.
- R3: An error that rises one clock after the acknowledge, with halt negated, is treated exactly as in R2 and not as a normal completion.
- R4: For a read or a write, error and halt together end the cycle and park the bus. After halt is negated the block reruns the cycle with identical address, function code and write data. If that rerun is acknowledged, the status is 2 (retried-ok) and no exception is raised.
- R5: A late error (as in R3) that arrives with halt asserted starts the same replay as R4.
- R6: A read-modify-write is never replayed. An error in either portion ends with status 1 and an exception, with or without halt. `exc_rmw_wr` is 1 only when the error hit the write portion.
- R7: While the error input stays asserted after a termination, `bus_addr_oe` and `bus_data_oe` are 0, and `exc_req` is raised only after the error input has been seen negated.
- R8: Halt asserted alone during a cycle lets that cycle complete normally. While halt remains asserted, `req_ready` and the address strobe stay low.
- R9: If, during a park, the error input is not negated at least one clock before halt, the cycle is not replayed. A `proto_viol` pulse is given, the status is 3 (halted), and no exception is raised.
- R10: In a read-modify-write the address strobe stays asserted from the start of the read portion through the end of the write portion. The data strobe pulses once for each portion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Block accepts the request this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_fc | input | FCW | Function code |
| req_addr | input | AW | Address |
| req_wdata | input | DW | Write data |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_fc | output | FCW | Function code on the bus |
| bus_addr | output | AW | Address on the bus |
| bus_addr_oe | output | 1 | Address and function code drive enable |
| bus_wdata | output | DW | Write data on the bus |
| bus_data_oe | output | 1 | Data drive enable |
| bus_rdata | input | DW | Read data from the bus |
| bus_ack | input | 1 | Data acknowledge (asynchronous) |
| bus_err | input | 1 | Bus error (asynchronous) |
| bus_halt | input | 1 | Halt (asynchronous) |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 bus error, 2 retried-ok, 3 halted |
| done_rdata | output | DW | Captured read data |
| exc_req | output | 1 | One-cycle bus-error exception request |
| exc_vector | output | 8 | Exception vector number (2) |
| exc_rmw_wr | output | 1 | Error hit a read-modify-write write portion |
| proto_viol | output | 1 | Error and halt released in the wrong order |

## Verification
The bench sweeps every request kind against every ending: acknowledge, early error, late error, error with halt, late error with halt, and halt released together with error. For read-modify-write it also sweeps which portion fails. A sequencer that ignored the late-error window would report ok where a bus error is due. One that replayed read-modify-write cycles would show a second read strobe and status 2 instead of an exception. The bench compares the address, function code and data of the two attempts on a replay, which catches a replay that used stale or changed fields. It checks that the enables fall and no exception fires while the error is held, that a halt alone blocks the next request but not the current one, and that a release in the wrong order gives the halted status rather than a silent replay.

// File: rtl/berh_pkg.sv
package berh_pkg;
  typedef enum logic [1:0] {K_READ = 2'd0, K_WRITE = 2'd1, K_RMW = 2'd2} kind_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_BERR = 2'd1, ST_RETRY_OK = 2'd2, ST_HALTED = 2'd3} stat_e;
  typedef enum logic [2:0] {S_IDLE, S_GAP, S_RUN, S_LATE, S_PARK, S_EHOLD} fsm_e;
  localparam logic [7:0] BERR_VECTOR = 8'd2;
endpackage

// File: rtl/berh_sync.sv
module berh_sync #(
  parameter int W = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/berh_req_hold.sv
module berh_req_hold #(
  parameter int AW  = 23,
  parameter int DW  = 16,
  parameter int FCW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [1:0]     kind_in,
  input  logic [FCW-1:0] fc_in,
  input  logic [AW-1:0]  addr_in,
  input  logic [DW-1:0]  wdata_in,
  output logic [1:0]     kind_q,
  output logic [FCW-1:0] fc_q,
  output logic [AW-1:0]  addr_q,
  output logic [DW-1:0]  wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= '0;
      fc_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      kind_q  <= kind_in;
      fc_q    <= fc_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end
endmodule

// File: rtl/berh_seq.sv
module berh_seq
  import berh_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [1:0]    kind_q,
  input  logic          a_s,
  input  logic          e_s,
  input  logic          h_s,
  input  logic [DW-1:0] bus_rdata,
  output logic          load,
  output logic          req_ready,
  output logic          as_on,
  output logic          ds_on,
  output logic          rd_phase,
  output logic          addr_oe,
  output logic          data_oe,
  output logic          done_valid,
  output logic [1:0]    done_status,
  output logic [DW-1:0] done_rdata,
  output logic          exc_req,
  output logic          exc_rmw_wr,
  output logic          proto_viol
);
  fsm_e          state_q;
  logic          wr_ph_q, retried_q, e_prev_q;
  stat_e         status_q;
  logic [DW-1:0] rdata_q;
  logic          rmw, driving;

  assign rmw       = (kind_q == K_RMW);
  assign req_ready = (state_q == S_IDLE) && !h_s;
  assign load      = req_ready && req_valid;
  assign driving   = (state_q == S_RUN) || (state_q == S_LATE) || (state_q == S_GAP);
  assign ds_on     = (state_q == S_RUN) || (state_q == S_LATE);
  assign as_on     = ds_on || ((state_q == S_GAP) && rmw && wr_ph_q);
  assign addr_oe   = driving;
  assign data_oe   = driving && wr_ph_q;
  assign rd_phase  = !wr_ph_q;
  assign done_status = status_q;
  assign done_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      wr_ph_q    <= 1'b0;
      retried_q  <= 1'b0;
      e_prev_q   <= 1'b0;
      status_q   <= ST_OK;
      rdata_q    <= '0;
      done_valid <= 1'b0;
      exc_req    <= 1'b0;
      exc_rmw_wr <= 1'b0;
      proto_viol <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      exc_req    <= 1'b0;
      exc_rmw_wr <= 1'b0;
      proto_viol <= 1'b0;
      e_prev_q   <= e_s;
      case (state_q)
        S_IDLE: if (load) begin
          state_q   <= S_GAP;
          wr_ph_q   <= (req_kind == K_WRITE);
          retried_q <= 1'b0;
        end
        S_GAP: if (!a_s && !e_s) state_q <= S_RUN;
        S_RUN, S_LATE: begin
          if (e_s) begin
            state_q <= (h_s && !rmw) ? S_PARK : S_EHOLD;
          end else if (state_q == S_RUN) begin
            if (a_s) begin
              state_q <= S_LATE;
              if (!wr_ph_q) rdata_q <= bus_rdata;
            end
          end else if (rmw && !wr_ph_q) begin
            wr_ph_q <= 1'b1;
            state_q <= S_GAP;
          end else begin
            state_q    <= S_IDLE;
            done_valid <= 1'b1;
            status_q   <= retried_q ? ST_RETRY_OK : ST_OK;
          end
        end
        S_PARK: if (!h_s) begin
          if (!e_s && !e_prev_q) begin
            retried_q <= 1'b1;
            state_q   <= S_GAP;
          end else begin
            state_q    <= S_IDLE;
            done_valid <= 1'b1;
            status_q   <= ST_HALTED;
            proto_viol <= 1'b1;
          end
        end
        S_EHOLD: if (!e_s) begin
          state_q    <= S_IDLE;
          done_valid <= 1'b1;
          status_q   <= ST_BERR;
          exc_req    <= 1'b1;
          exc_rmw_wr <= rmw && wr_ph_q;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);
  assert_exc_is_berr_R2: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (done_valid && done_status == ST_BERR));
  assert_rmw_no_park_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_PARK) |-> (kind_q != K_RMW));
  assert_exc_after_err_low_R7: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> !$past(e_s));
  assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && h_s) |=> (state_q == S_IDLE));
  assert_viol_no_exc_R9: assert property (@(posedge clk) disable iff (rst)
    proto_viol |-> (!exc_req && done_status == ST_HALTED));
endmodule

// File: rtl/bus_err_retry_ctrl.sv
module bus_err_retry_ctrl
  import berh_pkg::*;
#(
  parameter int AW  = 23,
  parameter int DW  = 16,
  parameter int FCW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_kind,
  input  logic [FCW-1:0] req_fc,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           bus_as,
  output logic           bus_ds,
  output logic           bus_rw,
  output logic [FCW-1:0] bus_fc,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_addr_oe,
  output logic [DW-1:0]  bus_wdata,
  output logic           bus_data_oe,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ack,
  input  logic           bus_err,
  input  logic           bus_halt,
  output logic           done_valid,
  output logic [1:0]     done_status,
  output logic [DW-1:0]  done_rdata,
  output logic           exc_req,
  output logic [7:0]     exc_vector,
  output logic           exc_rmw_wr,
  output logic           proto_viol
);
  localparam int NSYNC = 3;
  logic [NSYNC-1:0] raw_in, syn_q;
  logic             load;
  logic [1:0]       kind_q;

  assign raw_in     = {bus_halt, bus_err, bus_ack};
  assign exc_vector = BERR_VECTOR;

  berh_sync #(.W(NSYNC), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_q)
  );

  berh_req_hold #(.AW(AW), .DW(DW), .FCW(FCW)) u_hold (
    .clk(clk), .rst(rst), .load(load),
    .kind_in(req_kind), .fc_in(req_fc), .addr_in(req_addr), .wdata_in(req_wdata),
    .kind_q(kind_q), .fc_q(bus_fc), .addr_q(bus_addr), .wdata_q(bus_wdata)
  );

  berh_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .kind_q(kind_q),
    .a_s(syn_q[0]), .e_s(syn_q[1]), .h_s(syn_q[2]), .bus_rdata(bus_rdata),
    .load(load), .req_ready(req_ready), .as_on(bus_as), .ds_on(bus_ds), .rd_phase(bus_rw),
    .addr_oe(bus_addr_oe), .data_oe(bus_data_oe),
    .done_valid(done_valid), .done_status(done_status), .done_rdata(done_rdata),
    .exc_req(exc_req), .exc_rmw_wr(exc_rmw_wr), .proto_viol(proto_viol)
  );

  assert_replay_fields_R4: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !done_valid && $past(!req_ready)) |-> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_wdata)));
endmodule

// File: tb/tb_bus_err_retry_ctrl.sv
module tb_bus_err_retry_ctrl;
  localparam int AW = 23, DW = 16, FCW = 3;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic [FCW-1:0] req_fc = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
  logic bus_as, bus_ds, bus_rw, bus_addr_oe, bus_data_oe;
  logic [FCW-1:0] bus_fc;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, done_rdata;
  logic bus_ack = 1'b0, bus_err = 1'b0, bus_halt = 1'b0;
  logic done_valid, exc_req, exc_rmw_wr, proto_viol;
  logic [1:0] done_status;
  logic [7:0] exc_vector;

  always #10 clk = ~clk;

  bus_err_retry_ctrl #(.AW(AW), .DW(DW), .FCW(FCW)) dut (.*);

  int total = 0, bad = 0;
  int done_cnt = 0, exc_cnt = 0, viol_cnt = 0, ds_rises = 0, as_rises = 0;
  logic [1:0] last_status;
  logic [DW-1:0] last_rdata;
  logic [7:0] last_vec;
  logic last_exc_wr;
  logic [AW-1:0] cur_addr = '0, prv_addr = '0;
  logic [FCW-1:0] cur_fc = '0, prv_fc = '0;
  logic [DW-1:0] cur_wd = '0, prv_wd = '0;
  logic ds_p = 1'b0, as_p = 1'b0;

  always @(negedge clk) begin
    if (done_valid) begin done_cnt++; last_status = done_status; last_rdata = done_rdata; end
    if (exc_req) begin exc_cnt++; last_vec = exc_vector; last_exc_wr = exc_rmw_wr; end
    if (proto_viol) viol_cnt++;
    if (bus_ds && !ds_p) begin
      ds_rises++;
      prv_addr = cur_addr; prv_fc = cur_fc; prv_wd = cur_wd;
      cur_addr = bus_addr; cur_fc = bus_fc; cur_wd = bus_wdata;
    end
    if (bus_as && !as_p) as_rises++;
    ds_p = bus_ds; as_p = bus_as;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_ds();
    for (int t = 0; t < 300 && !bus_ds; t++) @(negedge clk);
  endtask
  task automatic wait_nods();
    for (int t = 0; t < 300 && bus_ds; t++) @(negedge clk);
  endtask
  task automatic wait_done(input int base);
    for (int t = 0; t < 400 && done_cnt == base; t++) @(negedge clk);
  endtask

  task automatic issue(input int k, input int idx);
    req_kind = 2'(k); req_addr = AW'(32'h1000 + idx * 4);
    req_fc = FCW'(idx); req_wdata = DW'(16'hA500 ^ idx);
    bus_rdata = DW'(16'h3C00 + idx);
    req_valid = 1'b1;
    for (int t = 0; t < 300 && !req_ready; t++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic resp_ack();
    wait_ds(); @(negedge clk); bus_ack = 1'b1;
    wait_nods(); bus_ack = 1'b0;
  endtask

  // err held for several clocks after ds falls; checks enables and exception meanwhile (R7)
  task automatic resp_err(input bit h, input bit late, input bit clean, output bit hiz_ok);
    int e0;
    wait_ds(); @(negedge clk);
    if (late) begin bus_ack = 1'b1; @(negedge clk); end
    bus_err = 1'b1; bus_halt = h;
    wait_nods();
    e0 = exc_cnt; hiz_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (bus_addr_oe || bus_data_oe || exc_cnt != e0) hiz_ok = 1'b0;
    end
    bus_ack = 1'b0;
    if (clean) begin bus_err = 1'b0; repeat (2) @(negedge clk); bus_halt = 1'b0; end
    else begin bus_err = 1'b0; bus_halt = 1'b0; end
  endtask

  // mode: 0 ack, 1 err, 2 err+halt, 3 late err, 4 late err+halt, 5 err+halt released together
  task automatic run_case(input int k, input int mode, input int ph, input int idx);
    int b_done, b_exc, b_viol, b_ds, b_as, exp_st, exp_ds;
    bit rmw, retry, hz, hz_any;
    string tag;
    rmw = (k == 2);
    retry = !rmw && (mode == 2 || mode == 4);
    b_done = done_cnt; b_exc = exc_cnt; b_viol = viol_cnt; b_ds = ds_rises; b_as = as_rises;
    hz_any = 1'b1;
    issue(k, idx);
    if (mode == 0) begin
      resp_ack(); if (rmw) resp_ack();
    end else begin
      if (rmw && ph == 1) resp_ack();
      resp_err(mode == 2 || mode == 4 || mode == 5, mode == 3 || mode == 4, mode != 5, hz);
      hz_any = hz;
      if (retry) resp_ack();
    end
    wait_done(b_done);
    if (mode == 0) exp_st = 0;
    else if (retry) exp_st = 2;
    else if (!rmw && mode == 5) exp_st = 3;
    else exp_st = 1;
    exp_ds = rmw ? ((mode == 0) ? 2 : ph + 1) : (retry ? 2 : 1);
    case (mode)
      0: tag = rmw ? "R10" : "R1";
      1: tag = "R2";
      2: tag = "R4";
      3: tag = "R3";
      4: tag = "R5";
      default: tag = "R9";
    endcase
    if (rmw && mode != 0) tag = "R6";
    chk(done_cnt == b_done + 1, tag, "done pulses", done_cnt - b_done, 1);
    chk(last_status == 2'(exp_st), tag, "status", last_status, exp_st);
    chk(ds_rises - b_ds == exp_ds, tag, "data strobes", ds_rises - b_ds, exp_ds);
    chk(exc_cnt - b_exc == ((exp_st == 1) ? 1 : 0), tag, "exceptions", exc_cnt - b_exc, (exp_st == 1) ? 1 : 0);
    if (exp_st == 1) begin
      chk(last_vec == 8'd2, "R2", "vector", last_vec, 2);
      chk(last_exc_wr == (rmw && ph == 1), "R6", "write-portion flag", last_exc_wr, int'(rmw && ph == 1));
    end
    chk(viol_cnt - b_viol == ((exp_st == 3) ? 1 : 0), "R9", "violations", viol_cnt - b_viol, (exp_st == 3) ? 1 : 0);
    if (mode != 0) chk(hz_any, "R7", "hi-Z and no exception while error held", hz_any, 1);
    if (retry) begin
      chk(prv_addr == cur_addr, "R4", "replay address", cur_addr, prv_addr);
      chk(prv_fc == cur_fc && prv_wd == cur_wd, "R4", "replay fc/data", cur_wd, prv_wd);
    end
    if ((exp_st == 0 || exp_st == 2) && k != 1)
      chk(last_rdata == DW'(16'h3C00 + idx), "R1", "read data", last_rdata, 16'h3C00 + idx);
    if (rmw && mode == 0)
      chk(as_rises - b_as == 1, "R10", "address strobe pulses", as_rises - b_as, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    int idx = 0, b_done;
    bit blk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_as && !bus_ds && !bus_addr_oe && !bus_data_oe, "R1", "reset bus idle", bus_as, 0);
    chk(!done_valid && !exc_req && req_ready, "R1", "reset status idle", req_ready, 1);

    for (int k = 0; k < 3; k++)
      for (int mode = 0; mode < 6; mode++)
        for (int ph = 0; ph < ((k == 2 && mode != 0) ? 2 : 1); ph++) begin
          run_case(k, mode, ph, idx);
          idx++;
        end

    // R8: halt raised mid-cycle; cycle still completes, next one is held off
    b_done = done_cnt;
    issue(0, 60);
    wait_ds(); bus_halt = 1'b1;
    resp_ack();
    wait_done(b_done);
    chk(done_cnt == b_done + 1 && last_status == 2'd0, "R8", "cycle under halt completes", last_status, 0);
    repeat (3) @(negedge clk);
    req_kind = 2'd1; req_valid = 1'b1; blk = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (req_ready || bus_as) blk = 1'b0;
    end
    chk(blk, "R8", "no new cycle while halted", blk, 1);
    b_done = done_cnt;
    bus_halt = 1'b0;
    issue(1, 61);
    resp_ack();
    wait_done(b_done);
    chk(last_status == 2'd0, "R8", "cycle after halt release", last_status, 0);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule